// File: doc/BRIEF.md
# Dual-Space I2C Register Target

This block is an I2C target that answers on two 7-bit device identifiers. Identifier `1101111b` opens a register bank and identifier `1010111b` opens a small user memory. Both are held as on-chip 8-bit arrays with parameterizable depths. SCL and SDA are oversampled on a fast system clock through two-flop synchronizers, and START and STOP conditions are recognised on the synchronized lines. The target drives the bus only through an open-drain enable: when `sda_oe_o` is high, SDA is pulled low.

A single byte pointer is shared by both spaces. A write-type access loads the pointer from the byte that follows the identifier, and the data bytes after that are stored at incrementing addresses. A read-type access streams bytes from the pointer, either where a previous transfer left it (current-address read) or where a dummy write just placed it (random read). Every stored byte is also announced on a one-cycle write strobe with its space, address and data, so that neighbouring logic can observe it.

After reset, a power-up window of `PWRUP_CYCLES` clocks must elapse before any START is honoured. A STOP always returns the block to an idle standby state.

Top module: `dual_space_i2c_target`

## Requirements
- R1: A START (SDA falling while SCL is high) opens a transfer, and a STOP (SDA rising while SCL is high) closes one. A START that arrives within the first `PWRUP_CYCLES` clocks after reset is ignored, so the identifier that follows it gets no ACK.
- R2: The first byte after a START is a 7-bit identifier with the R/W bit as bit 0, where 1 means read. Identifier `1101111b` selects the register bank (space 0) and `1010111b` selects the user memory (space 1). Any other identifier gets no ACK, and the target then ignores the bus until the next START.
- R3: The target ACKs an accepted identifier, the word-address byte and every write data byte by pulling SDA low during the ninth SCL period. It changes `sda_oe_o` only while the synchronized SCL is low.
- R4: The byte that follows a write-type identifier loads the byte pointer. The pointer resets to 00h, so the first current-address read after a reset returns the byte stored at location 00h.
- R5: Write data bytes are stored at consecutive addresses starting at the pointer, until a STOP. Each stored byte raises `wr_stb_o` for exactly one clock, with `wr_space_o` (0 = register bank, 1 = user memory), `wr_addr_o` and `wr_data_o` valid in that clock.
- R6: A read sends bytes MSB first from the pointer location of the selected space and increments the pointer after each byte. Reading continues while the master ACKs the ninth bit. On a NACK, the target releases SDA and goes idle.
- R7: In a random read, the identifier after the repeated START must name the same space as the dummy-write identifier. If it does not, the target gives no ACK.
- R8: A read at or beyond a space's depth returns 00h. A write there is ACKed and strobed but not stored. A write to the last location leaves the pointer at last+1. The pointer never wraps: it holds at FFh.
- R9: A STOP at any point releases SDA and returns the target to standby. In standby, bytes clocked without a new START are not ACKed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| scl_i | input | 1 | Sensed SCL line level |
| sda_i | input | 1 | Sensed SDA line level |
| sda_oe_o | output | 1 | Open-drain enable; 1 pulls SDA low |
| wr_stb_o | output | 1 | One-cycle pulse for each stored write byte |
| wr_space_o | output | 1 | Space of the strobed write: 0 register bank, 1 user memory |
| wr_addr_o | output | 8 | Pointer value of the strobed write |
| wr_data_o | output | 8 | Data of the strobed write |

## Verification
The bench targets the pointer's hand-off between transfers. It reads the current address after a burst read; a design that reset the pointer on STOP would return the wrong location. It also reads past the last location of the user memory and of the register bank, where a wrapping pointer would return stored data instead of 00h. A random read whose repeated START names the other space must be refused; a design that compared only the R/W bit would ACK it. The bench also tests an identifier clocked in before the power-up window closes, an unknown identifier followed by more bytes, and a byte sent after STOP with no new START. In each of these cases a design that acknowledged anyway would pull SDA low during the ninth clock.

// File: rtl/dsi_pkg.sv
package dsi_pkg;

  localparam logic [6:0] ID_REGS = 7'b1101111;
  localparam logic [6:0] ID_USER = 7'b1010111;

  localparam logic SPACE_REGS = 1'b0;
  localparam logic SPACE_USER = 1'b1;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_DEC,
    ST_ACK,
    ST_TX,
    ST_MACK
  } dsi_state_e;

  typedef enum logic [1:0] {
    RX_ID,
    RX_WADDR,
    RX_WDATA
  } dsi_rx_e;

  // Pointer advance that holds at the top of the 8-bit range.
  function automatic logic [7:0] ptr_step(input logic [7:0] p);
    return (p == 8'hFF) ? p : p + 8'd1;
  endfunction

endpackage

// File: rtl/dsi_line_front.sv
module dsi_line_front #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);

  logic [SYNC_STAGES-1:0] scl_sync_q, sda_sync_q;
  logic                   scl_prev_q, sda_prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sync_q <= '1;
      sda_sync_q <= '1;
      scl_prev_q <= 1'b1;
      sda_prev_q <= 1'b1;
    end else begin
      scl_sync_q <= {scl_sync_q[SYNC_STAGES-2:0], scl_i};
      sda_sync_q <= {sda_sync_q[SYNC_STAGES-2:0], sda_i};
      scl_prev_q <= scl_s;
      sda_prev_q <= sda_s;
    end
  end

  always_comb begin
    scl_s     = scl_sync_q[SYNC_STAGES-1];
    sda_s     = sda_sync_q[SYNC_STAGES-1];
    scl_rise  = scl_s & ~scl_prev_q;
    scl_fall  = ~scl_s & scl_prev_q;
    start_det = scl_s & scl_prev_q & sda_prev_q & ~sda_s;
    stop_det  = scl_s & scl_prev_q & ~sda_prev_q & sda_s;
  end

endmodule

// File: rtl/dsi_pwrup.sv
module dsi_pwrup #(
  parameter int CYCLES = 64
) (
  input  logic clk,
  input  logic rst_n,
  output logic ready_o
);

  localparam int CW = $clog2(CYCLES + 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    ready_o = (cnt_q == CW'(CYCLES));
    cnt_d   = ready_o ? cnt_q : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

endmodule

// File: rtl/dsi_bank.sv
module dsi_bank #(
  parameter int DEPTH = 16
) (
  input  logic       clk,
  input  logic       we_i,
  input  logic [7:0] waddr_i,
  input  logic [7:0] wdata_i,
  input  logic [7:0] raddr_i,
  output logic [7:0] rdata_o
);

  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [7:0] mem [DEPTH];
  logic       w_in, r_in;

  always_comb begin
    w_in    = int'(waddr_i) < DEPTH;
    r_in    = int'(raddr_i) < DEPTH;
    rdata_o = r_in ? mem[raddr_i[IW-1:0]] : 8'h00;
  end

  always_ff @(posedge clk) begin
    if (we_i && w_in) mem[waddr_i[IW-1:0]] <= wdata_i;
  end

endmodule

// File: rtl/dsi_ctrl.sv
module dsi_ctrl
  import dsi_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ready_i,
  input  logic       sda_s,
  input  logic       scl_rise,
  input  logic       scl_fall,
  input  logic       start_det,
  input  logic       stop_det,
  input  logic [7:0] rd_data_i,
  output logic       sda_oe_o,
  output logic       space_o,
  output logic [7:0] ptr_o,
  output logic       wr_stb_o,
  output logic       wr_space_o,
  output logic [7:0] wr_addr_o,
  output logic [7:0] wr_data_o
);

  dsi_state_e state_q, state_d;
  dsi_rx_e    kind_q, kind_d;
  logic [2:0] bitc_q, bitc_d;
  logic [7:0] sh_q, sh_d;
  logic [7:0] ptr_q, ptr_d;
  logic       ack_q, ack_d;
  logic       rw_q, rw_d;
  logic       space_q, space_d;
  logic       pv_q, pv_d;
  logic       psp_q, psp_d;
  logic       oe_q, oe_d;
  logic       more_q, more_d;
  logic       wstb_q, wstb_d;
  logic       wsp_q, wsp_d;
  logic [7:0] wadr_q, wadr_d;
  logic [7:0] wdat_q, wdat_d;

  logic [7:0] rx_byte;
  logic       id_hit, id_space, id_ok;

  always_comb begin
    rx_byte  = {sh_q[6:0], sda_s};
    id_hit   = (rx_byte[7:1] == ID_REGS) || (rx_byte[7:1] == ID_USER);
    id_space = (rx_byte[7:1] == ID_USER) ? SPACE_USER : SPACE_REGS;
    // a read after a dummy write must name the same space
    id_ok    = id_hit && !(rx_byte[0] && pv_q && (id_space != psp_q));
  end

  always_comb begin
    state_d = state_q;  kind_d  = kind_q;   bitc_d  = bitc_q;
    sh_d    = sh_q;     ptr_d   = ptr_q;    ack_d   = ack_q;
    rw_d    = rw_q;     space_d = space_q;  pv_d    = pv_q;
    psp_d   = psp_q;    oe_d    = oe_q;     more_d  = more_q;
    wstb_d  = 1'b0;     wsp_d   = wsp_q;    wadr_d  = wadr_q;
    wdat_d  = wdat_q;

    if (start_det && ready_i) begin
      state_d = ST_RX;
      kind_d  = RX_ID;
      bitc_d  = 3'd0;
      oe_d    = 1'b0;
    end else if (stop_det) begin
      state_d = ST_IDLE;
      oe_d    = 1'b0;
      pv_d    = 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: ;
        ST_RX: if (scl_rise) begin
          sh_d   = rx_byte;
          bitc_d = bitc_q + 3'd1;
          if (bitc_q == 3'd7) begin
            state_d = ST_DEC;
            unique case (kind_q)
              RX_ID: begin
                ack_d = id_ok;
                if (id_ok) begin
                  space_d = id_space;
                  rw_d    = rx_byte[0];
                  if (!rx_byte[0]) begin
                    pv_d  = 1'b1;
                    psp_d = id_space;
                  end
                end
              end
              RX_WADDR: begin
                ack_d = 1'b1;
                ptr_d = rx_byte;
              end
              default: begin
                ack_d  = 1'b1;
                wstb_d = 1'b1;
                wsp_d  = space_q;
                wadr_d = ptr_q;
                wdat_d = rx_byte;
                ptr_d  = ptr_step(ptr_q);
              end
            endcase
          end
        end
        ST_DEC: if (scl_fall) begin
          if (ack_q) begin
            oe_d    = 1'b1;
            state_d = ST_ACK;
          end else begin
            state_d = ST_IDLE;
          end
        end
        ST_ACK: if (scl_fall) begin
          bitc_d = 3'd0;
          if (kind_q == RX_ID && rw_q) begin
            sh_d    = rd_data_i;
            oe_d    = ~rd_data_i[7];
            ptr_d   = ptr_step(ptr_q);
            state_d = ST_TX;
          end else begin
            oe_d    = 1'b0;
            state_d = ST_RX;
            kind_d  = (kind_q == RX_ID) ? RX_WADDR : RX_WDATA;
          end
        end
        ST_TX: if (scl_fall) begin
          if (bitc_q == 3'd7) begin
            oe_d    = 1'b0;
            state_d = ST_MACK;
          end else begin
            sh_d   = {sh_q[6:0], 1'b0};
            oe_d   = ~sh_q[6];
            bitc_d = bitc_q + 3'd1;
          end
        end
        ST_MACK: begin
          if (scl_rise) more_d = ~sda_s;
          if (scl_fall) begin
            if (more_q) begin
              sh_d    = rd_data_i;
              oe_d    = ~rd_data_i[7];
              ptr_d   = ptr_step(ptr_q);
              bitc_d  = 3'd0;
              state_d = ST_TX;
            end else begin
              state_d = ST_IDLE;
            end
          end
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;  kind_q  <= RX_ID;  bitc_q <= '0;
      sh_q    <= '0;       ptr_q   <= '0;     ack_q  <= 1'b0;
      rw_q    <= 1'b0;     space_q <= 1'b0;   pv_q   <= 1'b0;
      psp_q   <= 1'b0;     oe_q    <= 1'b0;   more_q <= 1'b0;
      wstb_q  <= 1'b0;     wsp_q   <= 1'b0;   wadr_q <= '0;
      wdat_q  <= '0;
    end else begin
      state_q <= state_d;  kind_q  <= kind_d;  bitc_q <= bitc_d;
      sh_q    <= sh_d;     ptr_q   <= ptr_d;   ack_q  <= ack_d;
      rw_q    <= rw_d;     space_q <= space_d; pv_q   <= pv_d;
      psp_q   <= psp_d;    oe_q    <= oe_d;    more_q <= more_d;
      wstb_q  <= wstb_d;   wsp_q   <= wsp_d;   wadr_q <= wadr_d;
      wdat_q  <= wdat_d;
    end
  end

  always_comb begin
    sda_oe_o   = oe_q;
    space_o    = space_q;
    ptr_o      = ptr_q;
    wr_stb_o   = wstb_q;
    wr_space_o = wsp_q;
    wr_addr_o  = wadr_q;
    wr_data_o  = wdat_q;
  end

endmodule

// File: rtl/dual_space_i2c_target.sv
module dual_space_i2c_target #(
  parameter int REG_DEPTH    = 32,
  parameter int USER_DEPTH   = 16,
  parameter int PWRUP_CYCLES = 64,
  parameter int SYNC_STAGES  = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe_o,
  output logic       wr_stb_o,
  output logic       wr_space_o,
  output logic [7:0] wr_addr_o,
  output logic [7:0] wr_data_o
);

  localparam int NSPACE = 2;

  logic [1:0] rst_pipe_q;
  logic       rst_int_n;
  logic       scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic       pwr_ready;
  logic       rd_space;
  logic [7:0] rd_ptr, rd_data;
  logic [7:0] bank_rd [NSPACE];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_int_n = rst_pipe_q[1];

  dsi_line_front #(.SYNC_STAGES(SYNC_STAGES)) u_front (
    .clk(clk), .rst_n(rst_int_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  dsi_pwrup #(.CYCLES(PWRUP_CYCLES)) u_pwrup (
    .clk(clk), .rst_n(rst_int_n), .ready_o(pwr_ready)
  );

  dsi_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_int_n), .ready_i(pwr_ready), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .start_det(start_det),
    .stop_det(stop_det), .rd_data_i(rd_data), .sda_oe_o(sda_oe_o),
    .space_o(rd_space), .ptr_o(rd_ptr), .wr_stb_o(wr_stb_o),
    .wr_space_o(wr_space_o), .wr_addr_o(wr_addr_o), .wr_data_o(wr_data_o)
  );

  for (genvar g = 0; g < NSPACE; g++) begin : g_space
    localparam int DEPTH = (g == 0) ? REG_DEPTH : USER_DEPTH;
    dsi_bank #(.DEPTH(DEPTH)) u_bank (
      .clk(clk),
      .we_i(wr_stb_o && (wr_space_o == 1'(g))),
      .waddr_i(wr_addr_o),
      .wdata_i(wr_data_o),
      .raddr_i(rd_ptr),
      .rdata_o(bank_rd[g])
    );
  end

  assign rd_data = bank_rd[rd_space];

endmodule

// File: rtl/dsi_checker.sv
module dsi_checker (
  input logic clk,
  input logic rst_n,
  input logic scl_s,
  input logic start_det,
  input logic stop_det,
  input logic ready,
  input logic sda_oe,
  input logic wr_stb
);

  // R1
  quiet_before_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ready |-> !sda_oe);

  // R1
  start_releases_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_det && ready) |=> !sda_oe);

  // R3
  pull_only_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_s);

  // R5
  strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |=> !wr_stb);

  // R9
  stop_releases_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !sda_oe);

endmodule

bind dual_space_i2c_target dsi_checker u_chk (
  .clk(clk), .rst_n(rst_int_n), .scl_s(scl_s), .start_det(start_det),
  .stop_det(stop_det), .ready(pwr_ready), .sda_oe(sda_oe_o), .wr_stb(wr_stb_o)
);

// File: tb/sim_dual_space_i2c_target.sv
module sim_dual_space_i2c_target;

  localparam int CLK_PERIOD = 10;
  localparam int Q = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       scl_m = 1'b1;
  logic       sda_m = 1'b1;
  logic       sda_bus;
  logic       sda_oe_o, wr_stb_o, wr_space_o;
  logic [7:0] wr_addr_o, wr_data_o;

  int n_tests = 0;
  int n_fail  = 0;
  int stb_cnt = 0;
  logic       last_sp;
  logic [7:0] last_ad, last_da;

  always #(CLK_PERIOD/2) clk = ~clk;
  assign sda_bus = sda_m & ~sda_oe_o;

  dual_space_i2c_target u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
    .sda_oe_o(sda_oe_o), .wr_stb_o(wr_stb_o), .wr_space_o(wr_space_o),
    .wr_addr_o(wr_addr_o), .wr_data_o(wr_data_o)
  );

  always @(negedge clk) begin
    if (wr_stb_o) begin
      stb_cnt <= stb_cnt + 1;
      last_sp <= wr_space_o;
      last_ad <= wr_addr_o;
      last_da <= wr_data_o;
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic i2c_start();
    sda_m = 1'b1; tick(Q);
    scl_m = 1'b1; tick(Q);
    sda_m = 1'b0; tick(Q);
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic i2c_stop();
    sda_m = 1'b0; tick(Q);
    scl_m = 1'b1; tick(Q);
    sda_m = 1'b1; tick(2*Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; tick(Q);
      scl_m = 1'b1; tick(2*Q);
      scl_m = 1'b0; tick(Q);
    end
    sda_m = 1'b1; tick(Q);
    scl_m = 1'b1; tick(Q);
    ack = ~sda_bus;
    tick(Q);
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic recv_byte(output logic [7:0] b, input logic give_ack);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      tick(Q);
      scl_m = 1'b1; tick(Q);
      b[i] = sda_bus;
      tick(Q);
      scl_m = 1'b0;
    end
    tick(Q);
    sda_m = ~give_ack; tick(Q);
    scl_m = 1'b1; tick(2*Q);
    scl_m = 1'b0; tick(Q);
    sda_m = 1'b1;
  endtask

  task automatic t_reset();
    rst_n = 1'b0; tick(4);
    chk("R9 reset sda_oe", int'(sda_oe_o), 0);
    chk("R5 reset wr_stb", int'(wr_stb_o), 0);
    rst_n = 1'b1;
  endtask

  task automatic t_powerup();
    logic a;
    tick(2);
    i2c_start();
    send_byte(8'hDE, a);
    chk("R1 id during power-up not acked", int'(a), 0);
    i2c_stop();
    tick(100);
  endtask

  task automatic t_write_regs();
    logic a; int base;
    base = stb_cnt;
    i2c_start();
    send_byte(8'hDE, a); chk("R2 register id ack", int'(a), 1);
    send_byte(8'h03, a); chk("R3 word address ack", int'(a), 1);
    send_byte(8'hA5, a); chk("R3 data ack", int'(a), 1);
    send_byte(8'h5A, a);
    send_byte(8'hC3, a); chk("R3 third data ack", int'(a), 1);
    i2c_stop();
    chk("R5 strobe count", stb_cnt - base, 3);
    chk("R5 last strobe space", int'(last_sp), 0);
    chk("R5 last strobe addr", int'(last_ad), 8'h05);
    chk("R5 last strobe data", int'(last_da), 8'hC3);
    i2c_start();
    send_byte(8'hDE, a); send_byte(8'h00, a); send_byte(8'h99, a);
    i2c_stop();
  endtask

  task automatic t_random_read();
    logic a; logic [7:0] d;
    i2c_start();
    send_byte(8'hDE, a); send_byte(8'h03, a);
    i2c_start();
    send_byte(8'hDF, a); chk("R7 matching read id ack", int'(a), 1);
    recv_byte(d, 1'b1);  chk("R6 first read byte", int'(d), 8'hA5);
    recv_byte(d, 1'b0);  chk("R6 second read byte", int'(d), 8'h5A);
    tick(2);
    chk("R6 SDA released after NACK", int'(sda_oe_o), 0);
    i2c_stop();
  endtask

  task automatic t_current_read();
    logic a; logic [7:0] d;
    i2c_start();
    send_byte(8'hDF, a); chk("R4 current read id ack", int'(a), 1);
    recv_byte(d, 1'b0);  chk("R4 current read keeps pointer", int'(d), 8'hC3);
    i2c_stop();
  endtask

  task automatic t_bad_id();
    logic a; int base;
    base = stb_cnt;
    i2c_start();
    send_byte(8'h90, a); chk("R2 unknown id not acked", int'(a), 0);
    send_byte(8'h03, a); chk("R2 byte after unknown id ignored", int'(a), 0);
    i2c_stop();
    chk("R2 no strobe after unknown id", stb_cnt - base, 0);
  endtask

  task automatic t_user_space();
    logic a; logic [7:0] d;
    i2c_start();
    send_byte(8'hAE, a); chk("R2 user id ack", int'(a), 1);
    send_byte(8'h03, a); send_byte(8'h77, a);
    i2c_stop();
    chk("R5 user strobe space", int'(last_sp), 1);
    i2c_start();
    send_byte(8'hAE, a); send_byte(8'h03, a);
    i2c_start(); send_byte(8'hAF, a);
    recv_byte(d, 1'b0); chk("R2 user space readback", int'(d), 8'h77);
    i2c_stop();
    i2c_start();
    send_byte(8'hDE, a); send_byte(8'h03, a);
    i2c_start(); send_byte(8'hDF, a);
    recv_byte(d, 1'b0); chk("R2 register space separate", int'(d), 8'hA5);
    i2c_stop();
  endtask

  task automatic t_mismatch();
    logic a;
    i2c_start();
    send_byte(8'hDE, a); send_byte(8'h03, a);
    i2c_start();
    send_byte(8'hAF, a); chk("R7 mismatched read id not acked", int'(a), 0);
    i2c_stop();
  endtask

  task automatic t_bounds();
    logic a; logic [7:0] d;
    i2c_start();
    send_byte(8'hAE, a); send_byte(8'h0F, a);
    send_byte(8'h11, a);
    send_byte(8'h22, a); chk("R8 write beyond depth acked", int'(a), 1);
    i2c_stop();
    chk("R8 beyond-depth strobe addr", int'(last_ad), 8'h10);
    i2c_start();
    send_byte(8'hAE, a); send_byte(8'h0F, a);
    i2c_start(); send_byte(8'hAF, a);
    recv_byte(d, 1'b1); chk("R8 last location", int'(d), 8'h11);
    recv_byte(d, 1'b0); chk("R8 past last reads 00", int'(d), 8'h00);
    i2c_stop();
    i2c_start();
    send_byte(8'hDE, a); send_byte(8'hFF, a); send_byte(8'h44, a);
    i2c_stop();
    i2c_start();
    send_byte(8'hDF, a);
    recv_byte(d, 1'b0); chk("R8 pointer holds at FF no wrap", int'(d), 8'h00);
    i2c_stop();
  endtask

  task automatic t_standby();
    logic a;
    send_byte(8'hDE, a);
    chk("R9 byte without START not acked", int'(a), 0);
    scl_m = 1'b1; tick(Q);
    sda_m = 1'b1; tick(Q);
  endtask

  task automatic t_pointer_reset();
    logic a; logic [7:0] d;
    rst_n = 1'b0; tick(4);
    rst_n = 1'b1; tick(150);
    i2c_start();
    send_byte(8'hDF, a);
    recv_byte(d, 1'b0); chk("R4 pointer 00 after reset", int'(d), 8'h99);
    i2c_stop();
  endtask

  initial begin
    t_reset();
    t_powerup();
    t_write_regs();
    t_random_read();
    t_current_read();
    t_bad_id();
    t_user_space();
    t_mismatch();
    t_bounds();
    t_standby();
    t_pointer_reset();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule